// File: doc/BRIEF.md
# Programmable Odd/Even Feedback Divider

This block divides a clock by a programmable whole-number ratio for the feedback path of a frequency synthesizer. The ratio is built from a 10-bit base field and a one-bit odd-adjust field. The total is twice the base plus four, plus the odd bit. Any ratio from 8 to 2055 can be set, odd or even. The base field is split across two byte-wide configuration registers, and the odd bit shares a third byte with an unrelated field. The block reads only the bits it owns from those bytes.

A new configuration is captured by a one-cycle load strobe. It is held as a pending ratio and takes over only when the current output period ends. The block drives a divided clock that is low for the first part of each period and high for the rest. It also drives a one-cycle terminal-count pulse in the last cycle of every period.

Top module: `fbdiv_top`

## Requirements
- R1: The division ratio N equals 2 × (PB + 4) + PO. PB[9:8] comes from bits 1..0 of `cfg_pb_hi`, PB[7:0] is the whole of `cfg_pb_lo`, and PO is bit 7 of `cfg_odd`.
- R2: The active ratio always lies between 8 (PB = 0, PO = 0) and 2055 (PB = 1023, PO = 1), and both limits divide correctly.
- R3: Bits 7..2 of `cfg_pb_hi` and bits 6..0 of `cfg_odd` have no effect on the ratio.
- R4: Each output period lasts N cycles. `fb_clk` is low for the first N − floor(N/2) cycles and high for the last floor(N/2) cycles. For odd N this is (N+1)/2 low and (N−1)/2 high; for even N each half is N/2.
- R5: `fb_tc` is high for exactly one cycle per period, in the last high cycle of `fb_clk`. `fb_clk` is low in the cycle after it.
- R6: A ratio loaded while a period is in progress does not change that period. It governs the periods after the next terminal count.
- R7: If several loads arrive before a terminal count, only the last one is used. A load sampled on the same clock edge that ends a period governs the very next period.
- R8: While `rst` is high on a clock edge, the counter clears, `fb_clk` and `fb_tc` go low, any pending ratio is dropped, and the active ratio returns to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pb_hi | input | 8 | Bits 1..0 are PB[9:8]; the other bits are ignored |
| cfg_pb_lo | input | 8 | PB[7:0] |
| cfg_odd | input | 8 | Bit 7 is the odd-adjust bit; bits 6..0 are ignored |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration bytes |
| fb_clk | output | 1 | Registered divided clock |
| fb_tc | output | 1 | Registered one-cycle terminal-count pulse |

## Verification
The bench targets both ratio limits, the odd and even members of neighbouring ratio pairs, and bytes whose ignored bits are all set. A divider that reads a stray bit from those bytes, or drops the +4 offset or the odd bit, would report the wrong period length. A divider that splits odd periods with the extra cycle in the high phase would show swapped low and high counts. Loads that arrive mid-period, back to back, or on the wrapping edge would catch a divider that cuts the running period short, keeps the first of two loads, or delays a same-edge load by one period. A reset during a long period with a load still pending would expose a divider that restores the pending ratio instead of 8.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned CFG_BYTE_W = 8;

  typedef struct packed {
    logic [CFG_BYTE_W-1:0] pb_hi;
    logic [CFG_BYTE_W-1:0] pb_lo;
    logic [CFG_BYTE_W-1:0] odd;
  } fbdiv_cfg_t;
endpackage

// File: rtl/fbdiv_field_asm.sv
module fbdiv_field_asm
  import fbdiv_pkg::*;
#(
  parameter int unsigned PB_W   = 10,
  parameter int unsigned PB_OFS = 4,
  parameter int unsigned RW     = 12
) (
  input  fbdiv_cfg_t    cfg,
  output logic [RW-1:0] ratio
);
  localparam int unsigned HI_BITS = PB_W - CFG_BYTE_W;

  logic [PB_W-1:0] base;
  logic            odd_bit;
  logic            unused_cfg_bits;

  // Only the owned bits are taken; charge-pump, reserved and reference-divider bits drop out.
  assign base            = {cfg.pb_hi[HI_BITS-1:0], cfg.pb_lo};
  assign odd_bit         = cfg.odd[CFG_BYTE_W-1];
  assign unused_cfg_bits = ^{cfg.pb_hi[CFG_BYTE_W-1:HI_BITS], cfg.odd[CFG_BYTE_W-2:0]};

  assign ratio = ((RW'(base) + RW'(PB_OFS)) << 1) | RW'(odd_bit);
endmodule

// File: rtl/fbdiv_ratio_stage.sv
module fbdiv_ratio_stage #(
  parameter int unsigned RW        = 12,
  parameter int unsigned RATIO_MIN = 8,
  parameter int unsigned RATIO_MAX = 2055
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] new_ratio,
  input  logic          wrap,
  output logic [RW-1:0] active_ratio
);
  logic [RW-1:0] pend_ratio;
  logic          pend_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_ratio <= RW'(RATIO_MIN);
      pend_ratio   <= '0;
      pend_valid   <= 1'b0;
    end else if (wrap) begin
      if (load)            active_ratio <= new_ratio;
      else if (pend_valid) active_ratio <= pend_ratio;
      pend_valid <= 1'b0;
    end else if (load) begin
      pend_ratio <= new_ratio;
      pend_valid <= 1'b1;
    end
  end

  p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active_ratio));

  p_same_edge_load_r7: assert property (@(posedge clk) disable iff (rst)
    (wrap && load) |=> (active_ratio == $past(new_ratio)));

  p_ratio_range_r2: assert property (@(posedge clk) disable iff (rst)
    (active_ratio >= RW'(RATIO_MIN)) && (active_ratio <= RW'(RATIO_MAX)));
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter #(
  parameter int unsigned RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio,
  output logic          wrap,
  output logic          clk_div,
  output logic          tc
);
  logic [RW-1:0] cnt;
  logic [RW-1:0] cnt_next;
  logic [RW-1:0] last_cnt;
  logic [RW-1:0] low_len;

  assign last_cnt = ratio - RW'(1);
  assign low_len  = (ratio + RW'(1)) >> 1;  // low phase takes the extra cycle of an odd ratio
  assign wrap     = (cnt == last_cnt);
  assign cnt_next = wrap ? '0 : cnt + RW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      clk_div <= 1'b0;
      tc      <= 1'b0;
    end else begin
      cnt     <= cnt_next;
      clk_div <= (cnt_next >= low_len);
      tc      <= (cnt_next == last_cnt);
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio);

  p_tc_in_high_r4: assert property (@(posedge clk) disable iff (rst)
    tc |-> clk_div);

  p_tc_single_r5: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  p_fall_after_tc_r5: assert property (@(posedge clk) disable iff (rst)
    tc |=> !clk_div);

  p_reset_quiet_r8: assert property (@(posedge clk)
    $past(rst) |-> (!clk_div && !tc && (cnt == '0)));
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int unsigned PB_W   = 10,
  parameter int unsigned PB_OFS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CFG_BYTE_W-1:0] cfg_pb_hi,
  input  logic [CFG_BYTE_W-1:0] cfg_pb_lo,
  input  logic [CFG_BYTE_W-1:0] cfg_odd,
  input  logic                  cfg_load,
  output logic                  fb_clk,
  output logic                  fb_tc
);
  localparam int unsigned RATIO_MIN = 2 * PB_OFS;
  localparam int unsigned RATIO_MAX = 2 * ((1 << PB_W) - 1 + PB_OFS) + 1;
  localparam int unsigned RW        = $clog2(RATIO_MAX + 1);

  fbdiv_cfg_t    cfg;
  logic [RW-1:0] new_ratio;
  logic [RW-1:0] active_ratio;
  logic          wrap;

  assign cfg = '{pb_hi: cfg_pb_hi, pb_lo: cfg_pb_lo, odd: cfg_odd};

  fbdiv_field_asm #(.PB_W(PB_W), .PB_OFS(PB_OFS), .RW(RW)) i_field_asm (
    .cfg   (cfg),
    .ratio (new_ratio)
  );

  fbdiv_ratio_stage #(.RW(RW), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)) i_ratio_stage (
    .clk          (clk),
    .rst          (rst),
    .load         (cfg_load),
    .new_ratio    (new_ratio),
    .wrap         (wrap),
    .active_ratio (active_ratio)
  );

  fbdiv_counter #(.RW(RW)) i_counter (
    .clk     (clk),
    .rst     (rst),
    .ratio   (active_ratio),
    .wrap    (wrap),
    .clk_div (fb_clk),
    .tc      (fb_tc)
  );
endmodule

// File: tb/test_fbdiv_top.sv
`timescale 1ns/1ps
module test_fbdiv_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_pb_hi = '0;
  logic [7:0] cfg_pb_lo = '0;
  logic [7:0] cfg_odd = '0;
  logic       cfg_load = 1'b0;
  logic       fb_clk;
  logic       fb_tc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fbdiv_top i_fbdiv_top (
    .clk(clk), .rst(rst), .cfg_pb_hi(cfg_pb_hi), .cfg_pb_lo(cfg_pb_lo),
    .cfg_odd(cfg_odd), .cfg_load(cfg_load), .fb_clk(fb_clk), .fb_tc(fb_tc)
  );

  // {pb_hi, pb_lo, odd, expected ratio}
  localparam int NVEC = 9;
  localparam logic [35:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'h00, 12'd8},     // R2 minimum
    {8'h00, 8'h00, 8'h80, 12'd9},     // R1 odd bit
    {8'h03, 8'hFF, 8'h80, 12'd2055},  // R2 maximum
    {8'h03, 8'hFF, 8'h00, 12'd2054},  // R1 even neighbour
    {8'hFC, 8'h00, 8'h7F, 12'd8},     // R3 ignored bits all set
    {8'h01, 8'h2C, 8'h80, 12'd609},   // R1 PB=300
    {8'h02, 8'h05, 8'h00, 12'd1042},  // R1 PB=517
    {8'hFC, 8'h01, 8'hFF, 12'd11},    // R3 with PB=1, PO=1
    {8'h00, 8'h02, 8'h00, 12'd12}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_load(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] od);
    cfg_pb_hi = hi; cfg_pb_lo = lo; cfg_odd = od; cfg_load = 1'b1;
  endtask

  // Advance to the first negedge sample that shows the terminal count.
  task automatic sync_tc(output int waited);
    waited = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); cfg_load = 1'b0; waited++;
      if (fb_tc) return;
    end
    waited = -1;
  endtask

  // Count one period starting at the next negedge; ends at the sample with fb_tc.
  task automatic measure(input int exp_n, input string tag);
    int lo = 0, hi = 0, bad = 0, ended = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); cfg_load = 1'b0;
      if (fb_clk) hi++;
      else begin
        lo++;
        if (hi > 0) bad++;
        if (fb_tc) bad++;
      end
      if (fb_tc) begin ended = 1; break; end
    end
    check(ended == 1 && (lo + hi) == exp_n, {tag, " period"}, lo + hi, exp_n);
    check(bad == 0 && lo == exp_n - exp_n / 2 && hi == exp_n / 2,
          {tag, " R4 low count"}, lo, exp_n - exp_n / 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    check(fb_clk == 1'b0, "R8 reset clk", fb_clk, 0);
    check(fb_tc == 1'b0, "R8 reset tc", fb_tc, 0);
    rst = 1'b0;

    // R8: ratio after reset is 8
    sync_tc(w);
    check(w > 0 && w <= 8, "R8 first tc", w, 8);
    measure(8, "R8 default ratio");

    // Table walk: R1, R2, R3
    for (int v = 0; v < NVEC; v++) begin
      drive_load(VEC[v][35:28], VEC[v][27:20], VEC[v][19:12]);
      sync_tc(w);
      measure(int'(VEC[v][11:0]), $sformatf("R1 vec%0d", v));
    end

    // R5: tc spacing equals ratio, one pulse per period (ratio 12 active)
    sync_tc(w);
    sync_tc(w);
    check(w == 12, "R5 tc spacing", w, 12);

    // R6: load mid-period does not shorten it
    drive_load(8'h00, 8'h01, 8'h00);          // ratio 10
    sync_tc(w);
    sync_tc(w);
    repeat (3) @(negedge clk);
    drive_load(8'h00, 8'h00, 8'h00);          // ratio 8
    sync_tc(w);
    check(w == 7, "R6 running period kept", w + 3, 10);
    measure(8, "R6 new ratio after tc");

    // R7: last of several loads wins
    drive_load(8'h00, 8'h06, 8'h00);          // ratio 20
    @(negedge clk);
    drive_load(8'h00, 8'h03, 8'h00);          // ratio 14
    sync_tc(w);
    measure(14, "R7 last load wins");

    // R7: load on the wrapping edge applies immediately
    sync_tc(w);
    drive_load(8'h00, 8'h00, 8'h80);          // ratio 9
    measure(9, "R7 same-edge load");

    // R8: reset mid-period with a pending load
    drive_load(8'h03, 8'hFF, 8'h00);          // ratio 2054
    sync_tc(w);
    repeat (100) @(negedge clk);
    drive_load(8'h00, 8'h00, 8'h80);          // pending ratio 9
    @(negedge clk); cfg_load = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(fb_clk == 1'b0, "R8 mid reset clk", fb_clk, 0);
    check(fb_tc == 1'b0, "R8 mid reset tc", fb_tc, 0);
    rst = 1'b0;
    sync_tc(w);
    measure(8, "R8 pending dropped");
    measure(8, "R8 ratio stays 8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule